// File: doc/BRIEF.md
# BCD 24-Hour Clock with Scanned Six-Digit Display

This block keeps the time of day as packed BCD: seconds and minutes run through 00 to 59, hours through 00 to 23. Time advances on a one-cycle-per-second enable (`sec_tick`), which comes from the system clock domain. Two set inputs let an operator move the minutes or the hours forward. While a set input is high, each second tick advances that field by one, as if a carry had arrived from the field below.

The three BCD values are also sent to a multiplexed six-digit seven-segment display. A separate enable (`scan_tick`) steps a digit index. On each scan tick the segment bus, the active-low digit selects and the decimal point are loaded together from registers, so a digit never shows a neighbour's segments. Decimal points mark the minutes-units and hours-units digits as separators.

Top module: `bcd_clock_scan`

## Requirements
- R1: On each clock with `sec_tick` high, seconds step by one in packed BCD: bits [6:4] hold tens and bits [3:0] hold units, and a units value of 9 rolls to 0 and carries into the tens. Without `sec_tick` all three time fields hold their values.
- R2: A second tick that finds seconds at 59 sets them to 00 and advances the minutes on the same clock edge. A minute advance that finds 59 sets the minutes to 00 and advances the hours on that same edge.
- R3: Hours use packed BCD, with bits [5:4] for tens and [3:0] for units. An hour advance at 23 gives 00.
- R4: A second tick with `set_min` high advances the minutes by exactly one. This holds even when the seconds wrap on that same tick. The advance can carry into the hours as in R2.
- R5: A second tick with `set_hour` high advances the hours by exactly one. This holds even when the minutes also carry on that tick.
- R6: An active-low `rst_n` clears, asynchronously, the time fields, the scan index, the segment bus and the decimal point to 0, and drives every digit select high.
- R7: Each `scan_tick` loads the display registers from the current index and then advances the index: 0 → 1 → 2 → 3 → 4 → 5 → 0. The indices map to digits as follows: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens. For index k, `dig_sel_n[k]` is low and all other select bits are high. The digit value shown is taken from the time as it stood before that clock edge.
- R8: `dp` is high only while index 2 or index 4 is displayed.
- R9: `seg` is active high, with bit 6 for segment a down to bit 0 for segment g. The digit codes are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R10: `seg`, `dig_sel_n` and `dp` change only on clocks where `scan_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-second enable |
| scan_tick | input | 1 | Digit scan enable |
| set_min | input | 1 | Advance minutes on each second tick |
| set_hour | input | 1 | Advance hours on each second tick |
| sec_bcd | output | 7 | Seconds, packed BCD |
| min_bcd | output | 7 | Minutes, packed BCD |
| hr_bcd | output | 6 | Hours, packed BCD |
| seg | output | 7 | Segments a..g, active high |
| dig_sel_n | output | 6 | Digit selects, active low |
| dp | output | 1 | Decimal point |

## Verification
The hardest event to reach from the ports is the full cascade: seconds, minutes and hours all wrapping on one edge at 23:59:59. With plain ticks this takes 86,400 seconds. The bench instead uses the set inputs to bring hours to 23 and minutes to 59, then lets the seconds run through their wrap. A second case drives the set inputs high on the very tick where a natural carry also arrives, to confirm that the two sources are ORed and the field advances only once. Random scan ticks, mixed with those sequences, cover every digit index against changing time values.

// File: rtl/bcd_clock_scan.sv
module bcd_clock_scan #(
  parameter int DIGITS = 6,
  localparam int IW = $clog2(DIGITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             scan_tick,
  input  logic             set_min,
  input  logic             set_hour,
  output logic [6:0]       sec_bcd,
  output logic [6:0]       min_bcd,
  output logic [5:0]       hr_bcd,
  output logic [6:0]       seg,
  output logic [DIGITS-1:0] dig_sel_n,
  output logic             dp
);

  function automatic logic [6:0] step60(input logic [6:0] v);
    if (v >= 7'h59)           return 7'h00;
    else if (v[3:0] == 4'd9)  return v + 7'd7;
    else                      return v + 7'd1;
  endfunction

  function automatic logic [5:0] step24(input logic [5:0] v);
    if (v >= 6'h23)           return 6'h00;
    else if (v[3:0] == 4'd9)  return v + 6'd7;
    else                      return v + 6'd1;
  endfunction

  function automatic logic [6:0] to_seg(input logic [3:0] d);
    case (d)
      4'h0: return 7'b1111110;
      4'h1: return 7'b0110000;
      4'h2: return 7'b1101101;
      4'h3: return 7'b1111001;
      4'h4: return 7'b0110011;
      4'h5: return 7'b1011011;
      4'h6: return 7'b1011111;
      4'h7: return 7'b1110000;
      4'h8: return 7'b1111111;
      4'h9: return 7'b1111011;
      4'hA: return 7'b1110111;
      4'hB: return 7'b0011111;
      4'hC: return 7'b1001110;
      4'hD: return 7'b0111101;
      4'hE: return 7'b1001111;
      default: return 7'b1000111;
    endcase
  endfunction

  logic        sec_wrap, min_adv, min_wrap, hr_adv;
  logic [IW-1:0] idx;
  logic [3:0]  digit;

  assign sec_wrap = sec_tick && (sec_bcd == 7'h59);
  assign min_adv  = sec_tick && (sec_wrap || set_min);
  assign min_wrap = min_adv && (min_bcd == 7'h59);
  assign hr_adv   = sec_tick && (min_wrap || set_hour);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_bcd <= '0;
      min_bcd <= '0;
      hr_bcd  <= '0;
    end else begin
      if (sec_tick) sec_bcd <= step60(sec_bcd);
      if (min_adv)  min_bcd <= step60(min_bcd);
      if (hr_adv)   hr_bcd  <= step24(hr_bcd);
    end
  end

  always_comb begin
    case (idx)
      3'd0:    digit = sec_bcd[3:0];
      3'd1:    digit = {1'b0, sec_bcd[6:4]};
      3'd2:    digit = min_bcd[3:0];
      3'd3:    digit = {1'b0, min_bcd[6:4]};
      3'd4:    digit = hr_bcd[3:0];
      3'd5:    digit = {2'b00, hr_bcd[5:4]};
      default: digit = 4'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      seg       <= '0;
      dig_sel_n <= '1;
      dp        <= 1'b0;
    end else if (scan_tick) begin
      idx       <= (idx == IW'(DIGITS - 1)) ? '0 : idx + 1'b1;
      seg       <= to_seg(digit);
      dig_sel_n <= ~(DIGITS'(1) << idx);
      dp        <= (idx == 3'd2) || (idx == 3'd4);
    end
  end

  assert_sec_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bcd <= 7'h59 && sec_bcd[3:0] <= 4'd9);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(sec_bcd) && $stable(min_bcd) && $stable(hr_bcd));
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec_bcd == 7'h59) |=> sec_bcd == 7'h00);
  assert_hr_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hr_bcd <= 6'h23 && hr_bcd[3:0] <= 4'd9);
  assert_sel_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_sel_n) <= 1);
  assert_dp_place_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dp |-> (dig_sel_n == 6'b111011 || dig_sel_n == 6'b101111));
  assert_scan_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(seg) && $stable(dig_sel_n) && $stable(dp));

endmodule

// File: tb/test_bcd_clock_scan.sv
module test_bcd_clock_scan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_tick = 0, scan_tick = 0, set_min = 0, set_hour = 0;
  logic [6:0] sec_bcd, min_bcd, seg;
  logic [5:0] hr_bcd, dig_sel_n;
  logic dp;

  bcd_clock_scan i_bcd_clock_scan (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int s = 0, m = 0, h = 0, k = 0;
  logic [6:0] e_seg = 0;
  logic [5:0] e_sel = 6'h3f;
  logic e_dp = 0;

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic logic [6:0] segs(input int d);
    case (d)
      0: return 7'b1111110;  1: return 7'b0110000;
      2: return 7'b1101101;  3: return 7'b1111001;
      4: return 7'b0110011;  5: return 7'b1011011;
      6: return 7'b1011111;  7: return 7'b1110000;
      8: return 7'b1111111;  9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s = 0; m = 0; h = 0; k = 0; e_seg = 0; e_sel = 6'h3f; e_dp = 0;
    end else begin
      if (scan_tick) begin
        int d;
        case (k)
          0: d = s % 10;  1: d = s / 10;
          2: d = m % 10;  3: d = m / 10;
          4: d = h % 10;  default: d = h / 10;
        endcase
        e_seg = segs(d);
        e_sel = ~(6'd1 << k);
        e_dp  = (k == 2) || (k == 4);
        k = (k + 1) % 6;
      end
      if (sec_tick) begin
        bit mc, madv, hadv;
        madv = (s == 59) || set_min;
        s = (s + 1) % 60;
        mc = madv && (m == 59);
        if (madv) m = (m + 1) % 60;
        hadv = mc || set_hour;
        if (hadv) h = (h + 1) % 24;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 seconds", sec_bcd, bcd(s));
    chk("R2/R4 minutes", min_bcd, bcd(m));
    chk("R3/R5 hours", hr_bcd, bcd(h));
    chk("R7/R10 selects", dig_sel_n, e_sel);
    chk("R8 dp", dp, e_dp);
    chk("R9/R10 segments", seg, e_seg);
  endtask

  task automatic step(input bit st, input bit sc, input bit sm, input bit sh);
    sec_tick = st; scan_tick = sc; set_min = sm; set_hour = sh;
    @(posedge clk); cyc++;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 reset sec", sec_bcd, 0);
    chk("R6 reset sel", dig_sel_n, 6'h3f);
    chk("R6 reset dp", dp, 0);
    chk("R6 reset seg", seg, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 200; i++) step(1, 1, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 1, 0, 0);
    for (int i = 0; i < 130; i++) step(1, ($urandom % 3) == 0, 1, 0);
    for (int i = 0; i < 60; i++) step(1, 1, 0, 1);
    // R4/R5: set pulses coinciding with natural carries
    while (s != 59) step(1, 0, 0, 0);
    step(1, 1, 1, 0);
    while (m != 59) step(1, 0, 1, 0);
    while (s != 59) step(1, 0, 0, 0);
    step(1, 1, 0, 1);
    // R3: cascade 23:59:59 -> 00:00:00
    while (h != 23) step(1, 1, 0, 1);
    while (m != 59) step(1, 1, 1, 0);
    while (s != 59) step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    chk("R3 cascade hours", hr_bcd, 0);
    chk("R2 cascade minutes", min_bcd, 0);
    for (int i = 0; i < 4000; i++)
      step($urandom % 2, $urandom % 2, ($urandom % 8) == 0, ($urandom % 8) == 0);
    // R6 asynchronous reset mid-run
    #1 rst_n = 0;
    #0.5;
    chk("R6 async sec", sec_bcd, 0);
    chk("R6 async min", min_bcd, 0);
    chk("R6 async sel", dig_sel_n, 6'h3f);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 3000; i++) step(1, $urandom % 2, 0, ($urandom % 4) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule